// File: doc/BRIEF.md
# Motor Lock Protection Timer

This block guards a three-phase brushless motor drive against a stalled rotor. While the drive is running, it counts clock cycles since the last Hall-sensor transition. If that count reaches a programmed timeout, the block declares the rotor locked. It then asserts a high-side disable, which turns off the upper switches of the bridge, and raises a lock status flag.

The block recovers by itself. The lock is held for one more timeout period and then released, and the watch starts again from zero. A rotor that is still stuck therefore trips again after one full period. Drive retries in this way until the rotor turns.

The count responds to three controls:
- A power-save request clears the count and releases any lock.
- A thermal shutdown flag freezes the count and the state, keeping their values.
- An enable input switches the whole function off when low.

The timeout is a plain cycle count, set by a port.

Top module: `lock_guard`

## Requirements
- R1: With protectEnable high, powerSave low, thermalTrip low, driveActive high and hallEdge low, the count advances one per rising edge. lockActive goes high right after the max(timeoutCycles,1)-th consecutive such edge, counted from a cleared count.
- R2: highSideOff is high exactly when lockActive is high. Both are low after reset (rstN low, active-low asynchronous).
- R3: While not locked, a rising edge with hallEdge high or driveActive low clears the count. A full max(timeoutCycles,1) counting edges are then needed to trip.
- R4: Once locked, the block returns to watching after max(timeoutCycles,1) further edges without thermal hold. hallEdge and driveActive have no effect while locked.
- R5: powerSave high at a rising edge clears the count and makes lockActive low after that edge, whatever the state.
- R6: thermalTrip high (with powerSave low and protectEnable high) freezes both the count and lockActive. Counting resumes from the held value when it drops.
- R7: protectEnable low at a rising edge clears the count and forces lockActive low. With it held low, no lock occurs.
- R8: After an automatic release the count restarts at zero. A rotor that is still stopped trips again after exactly max(timeoutCycles,1) edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hallEdge | input | 1 | One-cycle pulse on any Hall-sensor transition |
| driveActive | input | 1 | Motor is being driven |
| powerSave | input | 1 | Power-save request; clears count and lock |
| thermalTrip | input | 1 | Thermal shutdown active; freezes count and state |
| protectEnable | input | 1 | Function enable; low disables protection |
| timeoutCycles | input | CNT_W | Trip and recovery period in cycles (0 behaves as 1) |
| highSideOff | output | 1 | Disable for the upper-side switches |
| lockActive | output | 1 | Locked-rotor protection in progress |

## Verification
The bench sweeps timeouts from 0 to 6 and measures three intervals in cycles: trip latency, lock duration and re-trip latency. An off-by-one in the terminal compare shows up as every interval being one cycle too long or too short. A design that mishandles a zero timeout would hang or trip at once.

Hall pulses and drive dropouts are injected part-way through a count. A design that merely paused on them would trip early. The same stimuli are repeated during a lock, where a design that listened to them would release late.

A thermal hold is placed both mid-count and mid-lock. Clearing instead of freezing would lengthen the remaining interval, and ignoring the hold would shorten it.

Power-save and enable are dropped during a lock, to catch a design that lets the lock ride out its full period.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

  typedef enum logic {
    ST_WATCH  = 1'b0,
    ST_LOCKED = 1'b1
  } lockState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } cntStrobe_t;

endpackage

// File: rtl/lock_guard_dpath.sv
module lock_guard_dpath
  import lock_guard_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] timeoutCycles,
  output logic             expired,
  output logic [CNT_W-1:0] cntVal
);

  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cntNext;
  logic [EXT_W-1:0] limitExt;

  assign cntNext  = {1'b0, cnt} + EXT_W'(1);
  assign limitExt = {1'b0, timeoutCycles};
  // zero timeout reads as one: any counting edge reaches it
  assign expired  = (cntNext >= limitExt);
  assign cntVal   = cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntInc) begin
      cnt <= cntNext[CNT_W-1:0];
    end
  end

  // R1: counter never wraps, since the terminal compare clears it first
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    cnt != {CNT_W{1'b1}});

  // R3/R8: a clear request is never combined with an increment
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.cntClr && strobe.cntInc));

endmodule

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lock_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hallEdge,
  input  logic       driveActive,
  input  logic       powerSave,
  input  logic       thermalTrip,
  input  logic       protectEnable,
  input  logic       expired,
  output cntStrobe_t strobe,
  output logic       lockActive
);

  lockState_e state, stateNext;
  logic       released;

  assign released = !protectEnable || powerSave;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (released) begin
      strobe.cntClr = 1'b1;
      stateNext     = ST_WATCH;
    end else if (thermalTrip) begin
      // frozen: no strobe, no transition
      stateNext = state;
    end else begin
      unique case (state)
        ST_WATCH: begin
          if (hallEdge || !driveActive) begin
            strobe.cntClr = 1'b1;
          end else if (expired) begin
            strobe.cntClr = 1'b1;
            stateNext     = ST_LOCKED;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        ST_LOCKED: begin
          if (expired) begin
            strobe.cntClr = 1'b1;
            stateNext     = ST_WATCH;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: begin
          strobe.cntClr = 1'b1;
          stateNext     = ST_WATCH;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WATCH;
    end else begin
      state <= stateNext;
    end
  end

  assign lockActive = (state == ST_LOCKED);

  // R5: power-save releases the lock at the following edge
  a_r5_powersave_release: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> !lockActive);

  // R7: disabled function never holds a lock
  a_r7_disable_release: assert property (@(posedge clk) disable iff (!rstN)
    !protectEnable |=> !lockActive);

  // R1: a trip only follows a cycle of driving with no Hall activity
  a_r1_trip_needs_drive: assert property (@(posedge clk) disable iff (!rstN)
    (!lockActive && hallEdge) |=> !lockActive);

  // R3: dropping drive while watching cannot cause a trip
  a_r3_idle_no_trip: assert property (@(posedge clk) disable iff (!rstN)
    (!lockActive && !driveActive) |=> !lockActive);

endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hallEdge,
  input  logic             driveActive,
  input  logic             powerSave,
  input  logic             thermalTrip,
  input  logic             protectEnable,
  input  logic [CNT_W-1:0] timeoutCycles,
  output logic             highSideOff,
  output logic             lockActive
);

  cntStrobe_t       strobe;
  logic             expired;
  logic [CNT_W-1:0] cntVal;

  lock_guard_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hallEdge      (hallEdge),
    .driveActive   (driveActive),
    .powerSave     (powerSave),
    .thermalTrip   (thermalTrip),
    .protectEnable (protectEnable),
    .expired       (expired),
    .strobe        (strobe),
    .lockActive    (lockActive)
  );

  lock_guard_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .timeoutCycles (timeoutCycles),
    .expired       (expired),
    .cntVal        (cntVal)
  );

  assign highSideOff = lockActive;

  // R6: thermal hold freezes count and protection state
  a_r6_thermal_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (thermalTrip && !powerSave && protectEnable) |=> ($stable(cntVal) && $stable(lockActive)));

  // R8: every automatic release starts the next watch from zero
  a_r8_release_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockActive) |-> (cntVal == '0));

  // R4: entering a lock starts the recovery count from zero
  a_r4_lock_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockActive) |-> (cntVal == '0));

endmodule

// File: tb/lock_guard_bench.sv
`timescale 1ns/1ps
module lock_guard_bench;

  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             hallEdge = 1'b0;
  logic             driveActive = 1'b0;
  logic             powerSave = 1'b0;
  logic             thermalTrip = 1'b0;
  logic             protectEnable = 1'b0;
  logic [CNT_W-1:0] timeoutCycles = '0;
  logic             highSideOff;
  logic             lockActive;

  int    nChecks = 0;
  int    nFails  = 0;
  string curReq  = "R2";

  // behavioural reference of the requirements
  logic  mLock = 1'b0;
  int    mCnt  = 0;

  always #4 clk = ~clk;

  lock_guard #(.CNT_W(CNT_W)) u_lock_guard (
    .clk           (clk),
    .rstN          (rstN),
    .hallEdge      (hallEdge),
    .driveActive   (driveActive),
    .powerSave     (powerSave),
    .thermalTrip   (thermalTrip),
    .protectEnable (protectEnable),
    .timeoutCycles (timeoutCycles),
    .highSideOff   (highSideOff),
    .lockActive    (lockActive)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLock <= 1'b0;
      mCnt  <= 0;
    end else begin
      int eff;
      eff = (timeoutCycles == 0) ? 1 : int'(timeoutCycles);
      if (!protectEnable || powerSave) begin
        mLock <= 1'b0;
        mCnt  <= 0;
      end else if (thermalTrip) begin
        mLock <= mLock;
      end else if (!mLock && (hallEdge || !driveActive)) begin
        mCnt <= 0;
      end else if (mCnt + 1 >= eff) begin
        mLock <= !mLock;
        mCnt  <= 0;
      end else begin
        mCnt <= mCnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      chk(lockActive == mLock, curReq, int'(lockActive), int'(mLock));
      chk(highSideOff == mLock, "R2", int'(highSideOff), int'(mLock));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // edges until lockActive reaches the wanted level
  task automatic measure(input logic want, input int exp, input string req);
    int n;
    n = 0;
    while (lockActive != want && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  task automatic clearAll();
    powerSave = 1'b1;
    cyc(1);
    powerSave = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    cyc(2);
    // R2: reset state
    chk(lockActive == 1'b0, "R2", int'(lockActive), 0);
    chk(highSideOff == 1'b0, "R2", int'(highSideOff), 0);
    @(negedge clk);
    rstN = 1'b1;
    protectEnable = 1'b1;
    cyc(2);

    // R1, R4, R8: latency sweep over small timeouts
    for (int t = 0; t <= 6; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      curReq = "R1";
      timeoutCycles = CNT_W'(t);
      driveActive = 1'b0;
      clearAll();
      driveActive = 1'b1;
      measure(1'b1, eff, "R1");
      curReq = "R4";
      measure(1'b0, eff, "R4");
      curReq = "R8";
      measure(1'b1, eff, "R8");
      clearAll();
    end

    // R3: Hall pulse and drive dropout restart the count
    curReq = "R3";
    timeoutCycles = CNT_W'(5);
    driveActive = 1'b1;
    cyc(3);
    hallEdge = 1'b1;
    cyc(1);
    hallEdge = 1'b0;
    measure(1'b1, 5, "R3");
    clearAll();
    cyc(4);
    driveActive = 1'b0;
    cyc(1);
    driveActive = 1'b1;
    measure(1'b1, 5, "R3");

    // R4: Hall and drive ignored while locked
    curReq = "R4";
    cyc(1);
    hallEdge = 1'b1;
    driveActive = 1'b0;
    cyc(1);
    hallEdge = 1'b0;
    chk(lockActive == 1'b1, "R4", int'(lockActive), 1);
    measure(1'b0, 3, "R4");
    driveActive = 1'b1;
    clearAll();

    // R6: thermal freeze mid-count and mid-lock
    curReq = "R6";
    timeoutCycles = CNT_W'(4);
    cyc(2);
    thermalTrip = 1'b1;
    cyc(7);
    chk(lockActive == 1'b0, "R6", int'(lockActive), 0);
    thermalTrip = 1'b0;
    measure(1'b1, 2, "R6");
    cyc(1);
    thermalTrip = 1'b1;
    cyc(9);
    chk(lockActive == 1'b1, "R6", int'(lockActive), 1);
    thermalTrip = 1'b0;
    measure(1'b0, 3, "R6");

    // R5: power-save drops a lock immediately
    curReq = "R5";
    measure(1'b1, 4, "R5");
    powerSave = 1'b1;
    thermalTrip = 1'b1;
    cyc(1);
    chk(lockActive == 1'b0, "R5", int'(lockActive), 0);
    powerSave = 1'b0;
    thermalTrip = 1'b0;
    measure(1'b1, 4, "R5");

    // R7: disable releases and prevents locking
    curReq = "R7";
    protectEnable = 1'b0;
    cyc(1);
    chk(lockActive == 1'b0, "R7", int'(lockActive), 0);
    cyc(20);
    chk(lockActive == 1'b0, "R7", int'(lockActive), 0);
    protectEnable = 1'b1;
    measure(1'b1, 4, "R7");

    cyc(3);
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule